// File: doc/BRIEF.md
# Crank-Angle Fuel Pulse Scheduler

This block drives the command line of one injector channel. In each engine cycle it opens one pulse: the pulse begins at a crank angle and lasts for a set time. The scheduler compares a free-running crank-position count with a programmed start angle and a cutoff angle. When the start angle is reached, it raises the command. It then times the pulse width in system clock ticks against a live 24-bit duration value. Crank position runs from 0 to `CYCLE_TICKS-1` and then wraps to 0. All angle distances are therefore measured forward, modulo that count.

The cutoff angle closes each cycle. When the crank position equals the cutoff, three things happen: any pulse still running ends, the channel rearms for the next cycle, and a sticky cutoff flag is set. Software can use this flag as a per-cycle event and clears it with a pulse on the clear input. Sometimes the start angle is already behind the crank when the channel is armed. If it is behind by less than a history window, the pulse fires late at full width. If it is behind by more, the cycle is skipped.

A second mode ignores angles. In this mode each rising edge of a strobe issues one pulse of the programmed width. There is no streaming data path. Every pin is a plain level control or status line, sampled on each clock.

Top module: `fuel_pulse_sched`

## Requirements
- R1: While reset is active and in the first cycle after reset, `inj_cmd` and `cutoff_flag` are low.
- R2: In angle mode, with `inj_en` high, the scheduler first evaluates the armed channel with `crank_pos == start_pos`. In that clock edge `inj_cmd` rises, and it stays high for exactly `duration` clock ticks. `duration` is an unsigned 24-bit tick count.
- R3: When an armed channel first sees a position that is 1 to `WIN_TICKS-1` ticks past `start_pos` (forward, modulo `CYCLE_TICKS`), the pulse starts in that edge at its full width.
- R4: A position that is at least `WIN_TICKS` past `start_pos` but still before `cutoff_pos` (forward distance from `start_pos` smaller than that of `cutoff_pos`) skips the cycle. No pulse is issued until the next cutoff.
- R5: An edge with `crank_pos == cutoff_pos` ends any pulse (`inj_cmd` low in the next cycle), rearms the channel and sets `cutoff_flag`. The flag stays set until an edge with `flag_clr` high. If set and clear fall in the same edge, the flag ends up set.
- R6: If `duration` is lowered during a pulse to a value no greater than the ticks already elapsed, the pulse ends at the next edge. If it is raised, the pulse runs on to the new total.
- R7: A change of `duration` after the pulse has ended but before cutoff starts no pulse. The new value sets the width of the next cycle's pulse.
- R8: With `imm_mode` high, each rising edge of `start_strobe` issues one pulse of `duration` ticks. A strobe held high issues no further pulse. Positions never start a pulse in this mode.
- R9: With `inj_en` low, `inj_cmd` is low. A start met while disabled is consumed for the cycle. Dropping `inj_en` during a pulse ends it.
- R10: `fault_dis` high forces `inj_cmd` low in the same cycle and ends the pulse in progress. The pulse does not resume when the fault clears.
- R11: In angle mode at most one pulse is issued between two cutoffs, even if the crank revisits `start_pos`.
- R12: A duration of zero issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pulse widths count its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Channel enable |
| imm_mode | input | 1 | 1: strobe-triggered mode, 0: angle mode |
| start_strobe | input | 1 | Trigger for the strobe mode (rising edge) |
| crank_pos | input | POS_W | Current crank-position count |
| start_pos | input | POS_W | Angle at which the pulse begins |
| cutoff_pos | input | POS_W | Angle that ends and rearms the cycle |
| duration | input | DUR_W | Pulse width in clock ticks |
| flag_clr | input | 1 | Clears the cutoff flag |
| fault_dis | input | 1 | Fault disable; forces the command off |
| inj_cmd | output | 1 | Injector command |
| cutoff_flag | output | 1 | Sticky cutoff event flag |

## Verification
Two collisions matter most.

The first is the cutoff event landing in the same edge as a flag clear. The bench holds the crank on the cutoff angle while pulsing `flag_clr`, and expects the flag to read set afterwards. It then clears the flag on a quiet position and expects it to read low.

The second is a live duration edit landing on the tick the timer compares. A pulse is held at the start angle, and `duration` is rewritten after a known number of high samples. The bench then judges the total high width against the arithmetic of elapsed ticks versus the new limit.

A sweep arms the channel and jumps the crank to every offset from the start angle up to the cutoff, for two start angles, one of them across the wrap. For each offset the bench predicts "full pulse at once" or "no pulse", depending on the window.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // Per-cycle arming state of the channel
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,   // waiting for the start condition
    ST_ACTIVE = 2'd1,   // command line high, width timer running
    ST_SPENT  = 2'd2    // fired or skipped; waits for cutoff
  } arm_state_e;

endpackage

// File: rtl/fps_angle_judge.sv
module fps_angle_judge #(
  parameter int POS_W       = 16,
  parameter int CYCLE_TICKS = 15360,
  parameter int WIN_TICKS   = 960
) (
  input  logic [POS_W-1:0] crank_pos,
  input  logic [POS_W-1:0] start_pos,
  input  logic [POS_W-1:0] cutoff_pos,
  output logic             at_cutoff,
  output logic             in_window,
  output logic             past_window
);

  localparam int XW = POS_W + 1;
  localparam logic [XW-1:0] CYC_X = XW'(CYCLE_TICKS);
  localparam logic [XW-1:0] WIN_X = XW'(WIN_TICKS);

  // forward distance from b to a, modulo the cycle length
  function automatic logic [XW-1:0] fwd_dist(input logic [POS_W-1:0] a,
                                             input logic [POS_W-1:0] b);
    logic [XW-1:0] ax, bx;
    ax = {1'b0, a};
    bx = {1'b0, b};
    if (ax >= bx) return ax - bx;
    else          return ax + CYC_X - bx;
  endfunction

  logic [XW-1:0] since_start;
  logic [XW-1:0] cut_span;

  always_comb begin
    since_start = fwd_dist(crank_pos, start_pos);
    cut_span    = fwd_dist(cutoff_pos, start_pos);
    at_cutoff   = (crank_pos == cutoff_pos);
    in_window   = (since_start < WIN_X);
    past_window = !in_window && (since_start < cut_span);
  end

endmodule

// File: rtl/fps_width_timer.sv
module fps_width_timer #(
  parameter int DUR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DUR_W-1:0] limit,
  output logic             expired
);

  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic [DUR_W-1:0] elapsed;

  // elapsed counts ticks of the live pulse; saturates at all-ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       elapsed <= '0;
    else if (load)                    elapsed <= ONE;
    else if (run && (elapsed != '1))  elapsed <= elapsed + ONE;
  end

  // compare against the live limit so mid-pulse edits take effect
  assign expired = (elapsed >= limit);

  AST_TIMER_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (elapsed >= $past(elapsed)));  // R6

endmodule

// File: rtl/fps_strobe_edge.sv
module fps_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);

  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe && !strobe_q;

endmodule

// File: rtl/fuel_pulse_sched.sv
module fuel_pulse_sched
  import fps_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int CYCLE_TICKS = 15360,
  parameter int WIN_TICKS   = CYCLE_TICKS / 16,
  parameter int DUR_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inj_en,
  input  logic             imm_mode,
  input  logic             start_strobe,
  input  logic [POS_W-1:0] crank_pos,
  input  logic [POS_W-1:0] start_pos,
  input  logic [POS_W-1:0] cutoff_pos,
  input  logic [DUR_W-1:0] duration,
  input  logic             flag_clr,
  input  logic             fault_dis,
  output logic             inj_cmd,
  output logic             cutoff_flag
);

  arm_state_e state_q, state_d;

  logic at_cutoff, in_window, past_window;
  logic strobe_rise;
  logic width_done;
  logic may_fire;
  logic fire_angle, skip_angle, fire_strobe;
  logic load_timer;

  fps_angle_judge #(
    .POS_W      (POS_W),
    .CYCLE_TICKS(CYCLE_TICKS),
    .WIN_TICKS  (WIN_TICKS)
  ) u_judge (
    .crank_pos  (crank_pos),
    .start_pos  (start_pos),
    .cutoff_pos (cutoff_pos),
    .at_cutoff  (at_cutoff),
    .in_window  (in_window),
    .past_window(past_window)
  );

  fps_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(start_strobe),
    .rise  (strobe_rise)
  );

  fps_width_timer #(.DUR_W(DUR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_timer),
    .run    (state_q == ST_ACTIVE),
    .limit  (duration),
    .expired(width_done)
  );

  always_comb begin
    may_fire    = inj_en && !fault_dis && (duration != '0);
    fire_angle  = !imm_mode && (state_q == ST_ARMED) && in_window;
    skip_angle  = !imm_mode && (state_q == ST_ARMED) && past_window;
    fire_strobe = imm_mode && strobe_rise && (state_q != ST_ACTIVE);

    state_d = state_q;
    if (at_cutoff) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_ARMED: begin
          if (fire_angle)       state_d = may_fire ? ST_ACTIVE : ST_SPENT;
          else if (skip_angle)  state_d = ST_SPENT;
          else if (fire_strobe && may_fire) state_d = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (!inj_en || fault_dis || width_done) state_d = ST_SPENT;
        end
        ST_SPENT: begin
          if (fire_strobe && may_fire) state_d = ST_ACTIVE;
        end
        default: state_d = ST_ARMED;
      endcase
    end
    load_timer = (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  // sticky cutoff flag: a set wins over a clear in the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cutoff_flag <= 1'b0;
    else if (at_cutoff) cutoff_flag <= 1'b1;
    else if (flag_clr)  cutoff_flag <= 1'b0;
  end

  assign inj_cmd = (state_q == ST_ACTIVE) && inj_en && !fault_dis;

  AST_CUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    at_cutoff |=> cutoff_flag);  // R5
  AST_CUT_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    at_cutoff |=> !inj_cmd);  // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cutoff_flag && !flag_clr) |=> cutoff_flag);  // R5
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_dis |=> !inj_cmd);  // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |=> !inj_cmd);  // R9
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_cmd && (duration == '0)) |=> !inj_cmd);  // R12
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SPENT) && !imm_mode && !at_cutoff) |=> !inj_cmd);  // R11
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inj_cmd) && $past(imm_mode)) |-> $past(start_strobe));  // R8

endmodule

// File: tb/tb_fuel_pulse_sched.sv
`timescale 1ns/100ps
module tb_fuel_pulse_sched;

  localparam int PW  = 6;
  localparam int CYC = 64;
  localparam int WIN = 8;
  localparam int DW  = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inj_en, imm_mode, start_strobe, flag_clr, fault_dis;
  logic [PW-1:0] crank_pos, start_pos, cutoff_pos;
  logic [DW-1:0] duration;
  logic          inj_cmd, cutoff_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fuel_pulse_sched #(
    .POS_W(PW), .CYCLE_TICKS(CYC), .WIN_TICKS(WIN), .DUR_W(DW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .imm_mode(imm_mode),
    .start_strobe(start_strobe), .crank_pos(crank_pos),
    .start_pos(start_pos), .cutoff_pos(cutoff_pos), .duration(duration),
    .flag_clr(flag_clr), .fault_dis(fault_dis),
    .inj_cmd(inj_cmd), .cutoff_flag(cutoff_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // run n edges; optionally advance the crank after each sample
  task automatic run_steps(input int n, input bit step, output int rise, output int width);
    rise = -1;
    width = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (inj_cmd) begin
        if (rise < 0) rise = i;
        width++;
      end
      if (step) crank_pos = PW'((int'(crank_pos) + 1) % CYC);
    end
  endtask

  task automatic arm();
    crank_pos = cutoff_pos;
    tick();
  endtask

  task automatic set_start(input int s);
    start_pos  = PW'(s);
    cutoff_pos = PW'((s + 32) % CYC);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int rs, w, w2, d;
    rst_n = 1'b0; inj_en = 1'b1; imm_mode = 1'b0; start_strobe = 1'b0;
    flag_clr = 1'b0; fault_dis = 1'b0; duration = 24'd5;
    crank_pos = '0;
    set_start(10);
    tick(); tick();
    chk(!inj_cmd && !cutoff_flag, "R1 reset", int'(inj_cmd) + int'(cutoff_flag), 0);
    rst_n = 1'b1;
    tick();
    chk(!inj_cmd && !cutoff_flag, "R1 after reset", int'(inj_cmd) + int'(cutoff_flag), 0);

    // offset sweep from the start angle, two starts, one across the wrap
    d = 5;
    duration = DW'(d);
    foreach (start_vals[j]) begin
      set_start(start_vals[j]);
      for (int k = 0; k < 32; k++) begin
        arm();
        crank_pos = PW'((start_vals[j] + k) % CYC);
        run_steps(32 - k, 1'b1, rs, w);
        if (k == 0)
          chk(rs == 0 && w == d, "R2 on-time pulse width", w, d);
        else if (k < WIN)
          chk(rs == 0 && w == d, "R3 late pulse inside window", w, d);
        else
          chk(w == 0, "R4 skip beyond window", w, 0);
      end
    end

    set_start(10);
    // R5 flag set, collision with clear, then clear
    arm();
    chk(cutoff_flag, "R5 flag set at cutoff", int'(cutoff_flag), 1);
    flag_clr = 1'b1;
    tick();
    chk(cutoff_flag, "R5 set wins over clear", int'(cutoff_flag), 1);
    crank_pos = 6'd20;
    tick();
    flag_clr = 1'b0;
    chk(!cutoff_flag, "R5 clear", int'(cutoff_flag), 0);
    tick(); tick();
    chk(!cutoff_flag, "R5 stays clear", int'(cutoff_flag), 0);

    // R5 cutoff truncates a running pulse
    duration = 24'd40;
    arm();
    crank_pos = 6'd10;
    run_steps(3, 1'b0, rs, w);
    crank_pos = cutoff_pos;
    tick();
    chk(!inj_cmd, "R5 cutoff ends pulse", int'(inj_cmd), 0);

    // R6 shorten mid-pulse
    duration = 24'd10;
    arm();
    crank_pos = 6'd10;
    run_steps(3, 1'b0, rs, w);
    chk(w == 3, "R6 pulse running", w, 3);
    duration = 24'd2;
    tick();
    chk(!inj_cmd, "R6 shortened pulse ends", int'(inj_cmd), 0);

    // R6 lengthen mid-pulse
    duration = 24'd4;
    arm();
    crank_pos = 6'd10;
    run_steps(2, 1'b0, rs, w);
    duration = 24'd7;
    run_steps(10, 1'b0, rs, w2);
    chk(w + w2 == 7, "R6 extended width", w + w2, 7);

    // R7 edit after the pulse ended
    duration = 24'd9;
    run_steps(6, 1'b0, rs, w);
    chk(w == 0, "R7 no refire after edit", w, 0);
    arm();
    crank_pos = 6'd10;
    run_steps(12, 1'b0, rs, w);
    chk(w == 9, "R7 next cycle uses edit", w, 9);

    // R11 revisit the start without a cutoff
    duration = 24'd3;
    arm();
    crank_pos = 6'd10;
    run_steps(5, 1'b1, rs, w);
    chk(w == 3, "R11 first pulse", w, 3);
    crank_pos = 6'd10;
    run_steps(4, 1'b0, rs, w);
    chk(w == 0, "R11 no second pulse", w, 0);

    // R12 zero width
    duration = 24'd0;
    arm();
    crank_pos = 6'd10;
    run_steps(6, 1'b1, rs, w);
    chk(w == 0, "R12 zero duration", w, 0);

    // R9 disabled at start, then re-enabled
    duration = 24'd4;
    arm();
    inj_en = 1'b0;
    crank_pos = 6'd10;
    run_steps(4, 1'b0, rs, w);
    chk(w == 0, "R9 disabled at start", w, 0);
    inj_en = 1'b1;
    run_steps(4, 1'b0, rs, w);
    chk(w == 0, "R9 start consumed", w, 0);
    arm();
    crank_pos = 6'd10;
    run_steps(2, 1'b0, rs, w);
    inj_en = 1'b0;
    #1;
    chk(!inj_cmd, "R9 drop enable mid-pulse", int'(inj_cmd), 0);
    tick();
    inj_en = 1'b1;
    run_steps(5, 1'b0, rs, w);
    chk(w == 0, "R9 pulse not resumed", w, 0);

    // R10 fault mid-pulse
    arm();
    crank_pos = 6'd10;
    run_steps(2, 1'b0, rs, w);
    fault_dis = 1'b1;
    #1;
    chk(!inj_cmd, "R10 fault forces low", int'(inj_cmd), 0);
    tick();
    fault_dis = 1'b0;
    run_steps(5, 1'b0, rs, w);
    chk(w == 0, "R10 no resume after fault", w, 0);

    // R8 strobe mode
    imm_mode = 1'b1;
    duration = 24'd3;
    arm();
    crank_pos = 6'd20;
    start_strobe = 1'b1;
    run_steps(8, 1'b0, rs, w);
    chk(rs == 0 && w == 3, "R8 strobe pulse", w, 3);
    start_strobe = 1'b0;
    tick();
    start_strobe = 1'b1;
    run_steps(6, 1'b0, rs, w);
    chk(w == 3, "R8 second strobe pulse", w, 3);
    start_strobe = 1'b0;
    arm();
    crank_pos = 6'd10;
    run_steps(4, 1'b0, rs, w);
    chk(w == 0, "R8 angle ignored in strobe mode", w, 0);
    imm_mode = 1'b0;

    finish_run();
  end

  int start_vals [2] = '{10, 50};

endmodule